// File: doc/BRIEF.md
# SD Command Path Engine

This block drives the command line of an SD/MMC host. Software writes a command word with the enable bit set, and the engine builds a 48-bit command frame from the index, the argument and a computed CRC7. It shifts the frame out one bit per clock. Depending on a 2-bit response code, it then either finishes at once or listens on the command line for a short (48-bit) or long (136-bit) reply. A reply is checked and then stored in four 32-bit response registers. After a reply, the engine can watch data line 0 while the card holds it low to signal busy. That watch is bounded by a data timer that is loaded when the command starts.

Results appear as sticky flags in a 32-bit status word. A write-1-to-clear port removes them. Two live bits in the status word show that the path is active and that the card is busy. The clock is the card bit clock, so every serial bit lasts one cycle.

Top module: `sd_cmd_path`

## Requirements
- R1: A started command is driven on `cmd_out` with `cmd_oe` high for exactly 48 cycles, MSB first, as {0, 1, index[5:0], argument[31:0], crc[6:0], 1}. The crc is CRC7 with polynomial x^7+x^3+1, computed over the first 40 bits. Index 0 with argument 0 gives frame 0x400000000095.
- R2: Command word fields are index in bits 5:0, response code in bits 9:8 and enable in bit 12. Status bit 13 is high while the path is busy. With response code 00, status bit 7 (sent) is set when the end bit completes and the path goes idle.
- R3: With code 01 or 10, a 48-bit reply {0, 0, index, data[31:0], crc, 1} sets status bit 6 and loads data into `resp0`. `resp1`..`resp3` keep their values.
- R4: With code 01, a reply whose CRC7 over its first 40 bits mismatches sets status bit 0 and not bit 6. With code 10, the CRC is not checked and bit 6 is set.
- R5: With code 11, a 136-bit reply is taken without a CRC check. Its bits 127:96, 95:64 and 63:32 go to `resp0`..`resp2`, and bits 31:1 with a zero LSB go to `resp3`. Status bit 6 is set.
- R6: If the command line stays high for 64 sampled cycles after the end bit, status bit 2 is set and the path goes idle.
- R7: If `dat0_in` is low when a good reply completes, status bit 20 is high while it stays low. Its return high clears bit 20, sets bit 21 and idles the path.
- R8: The busy wait allows `dtimer_in` (sampled at start) plus one cycles. If data line 0 is still low after that, status bit 3 is set and bit 20 drops.
- R9: Writing `clr_data` with `clr_wr` clears every flag whose bit is 1. Other flags keep their value.
- R10: A command write with the enable bit set while the path is busy is ignored. A command write with enable clear returns the path to idle on the next cycle and sets no flag.
- R11: After reset, the status is zero, `cmd_oe` is low and `cmd_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card bit clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 13 | Command word (index, flags, response code, enable) |
| arg_in | input | 32 | Command argument, sampled at start |
| dtimer_in | input | DTW | Busy timer reload, sampled at start |
| clr_wr | input | 1 | Flag clear strobe |
| clr_data | input | 32 | Write-1-to-clear mask |
| cmd_in | input | 1 | Command line from the card |
| dat0_in | input | 1 | Data line 0 from the card |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| status | output | 32 | Sticky flags and live state bits |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |

## Verification
The first frame bit appears in the cycle after the edge that takes the write. The sent flag is visible in the cycle after the 48th bit. A reply's flags and registers update in the cycle after the edge that samples its last bit. The timeout flag appears on the 64th high sample after the end bit. The busy timeout appears on the edge after the timer reaches zero.

The bench drives inputs at falling edges and reads outputs there. It counts rising edges from the cycle where `cmd_oe` falls or the last reply bit was driven. It checks one cycle before each due point that the flag is still clear, and on the due cycle that it is set.

// File: rtl/sd_cmd_path.sv
module sd_cmd_path #(
  parameter int CTO = 64,
  parameter int DTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic [12:0]     cmd_wdata,
  input  logic [31:0]     arg_in,
  input  logic [DTW-1:0]  dtimer_in,
  input  logic            clr_wr,
  input  logic [31:0]     clr_data,
  input  logic            cmd_in,
  input  logic            dat0_in,
  output logic            cmd_out,
  output logic            cmd_oe,
  output logic [31:0]     status,
  output logic [31:0]     resp0,
  output logic [31:0]     resp1,
  output logic [31:0]     resp2,
  output logic [31:0]     resp3
);
  localparam int TCW = (CTO > 1) ? $clog2(CTO) : 1;
  localparam logic [31:0] STATIC_MASK = 32'h1FE0_0FFF;

  typedef enum logic [2:0] {IDLE, SEND, WAIT, RECV, BUSY} st_t;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  st_t            st;
  logic [47:0]    sh;
  logic [7:0]     bcnt;
  logic [135:0]   rsr;
  logic [1:0]     wcode;
  logic [TCW-1:0] tcnt;
  logic [DTW-1:0] dcnt;
  logic [31:0]    flg;
  logic [31:0]    setv;

  wire  [39:0]  hdr    = {2'b01, cmd_wdata[5:0], arg_in};
  wire  [47:0]  frame  = {hdr, crc7(hdr), 1'b1};
  wire          start  = cmd_wr && cmd_wdata[12] && (st == IDLE);
  wire          abort  = cmd_wr && !cmd_wdata[12];
  wire          is_long = (wcode == 2'b11);
  wire  [7:0]   rlen   = is_long ? 8'd136 : 8'd48;
  wire  [135:0] rnext  = {rsr[134:0], cmd_in};
  wire          rdone  = (st == RECV) && (bcnt == rlen - 8'd1);
  wire          crc_bad = !is_long && (wcode == 2'b01) &&
                          (crc7(rnext[47:8]) != rnext[7:1]);

  assign cmd_oe  = (st == SEND);
  assign cmd_out = (st == SEND) ? sh[47] : 1'b1;
  assign status  = flg | (32'(st != IDLE) << 13) | (32'(st == BUSY) << 20);

  always_comb begin
    setv = '0;
    if (!abort) begin
      if (st == SEND && bcnt == 8'd47 && wcode == 2'b00) setv[7] = 1'b1;
      if (st == WAIT && cmd_in && tcnt == TCW'(CTO - 1)) setv[2] = 1'b1;
      if (rdone) begin
        if (crc_bad) setv[0] = 1'b1;
        else         setv[6] = 1'b1;
      end
      if (st == BUSY) begin
        if (dat0_in)           setv[21] = 1'b1;
        else if (dcnt == '0)   setv[3]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; sh <= '0; bcnt <= '0; rsr <= '0; wcode <= '0;
      tcnt <= '0; dcnt <= '0; flg <= '0;
      resp0 <= '0; resp1 <= '0; resp2 <= '0; resp3 <= '0;
    end else begin
      flg <= (flg & ~(clr_wr ? (clr_data & STATIC_MASK) : 32'h0)) | setv;
      if (abort) begin
        st <= IDLE;
      end else begin
        unique case (st)
          IDLE: if (start) begin
            sh <= frame; bcnt <= '0; wcode <= cmd_wdata[9:8];
            dcnt <= dtimer_in; st <= SEND;
          end
          SEND: begin
            sh   <= {sh[46:0], 1'b1};
            bcnt <= bcnt + 8'd1;
            tcnt <= '0;
            if (bcnt == 8'd47) st <= (wcode == 2'b00) ? IDLE : WAIT;
          end
          WAIT: begin
            if (!cmd_in) begin
              st <= RECV; bcnt <= 8'd1; rsr <= '0;
            end else if (tcnt == TCW'(CTO - 1)) begin
              st <= IDLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RECV: begin
            rsr  <= rnext;
            bcnt <= bcnt + 8'd1;
            if (rdone) begin
              if (crc_bad) begin
                st <= IDLE;
              end else begin
                if (is_long) begin
                  resp0 <= rnext[127:96]; resp1 <= rnext[95:64];
                  resp2 <= rnext[63:32];  resp3 <= {rnext[31:1], 1'b0};
                end else begin
                  resp0 <= rnext[39:8];
                end
                st <= dat0_in ? IDLE : BUSY;
              end
            end
          end
          BUSY: begin
            if (dat0_in || dcnt == '0) st <= IDLE;
            else dcnt <= dcnt - 1'b1;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sd_cmd_path_chk.sv
module sd_cmd_path_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_oe,
  input logic        dat0_in,
  input logic [31:0] status
);
  a_r2_drive_only_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> status[13]);
  a_r4_crc_fail_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> !$rose(status[6]));
  a_r6_timeout_idles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> !status[13]);
  a_r7_busy_end_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[21]) |-> $past(dat0_in));
  a_r7_busy_implies_active: assert property (@(posedge clk) disable iff (!rst_n)
    status[20] |-> status[13]);
  a_r8_timeout_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> !status[20]);
endmodule

bind sd_cmd_path sd_cmd_path_chk u_chk (.*);

// File: tb/sd_cmd_path_test.sv
module sd_cmd_path_test;
  localparam int DTW = 16;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cmd_wr, clr_wr, cmd_in, dat0_in;
  logic [12:0] cmd_wdata;
  logic [31:0] arg_in, clr_data;
  logic [DTW-1:0] dtimer_in;
  logic cmd_out, cmd_oe;
  logic [31:0] status, resp0, resp1, resp2, resp3;
  int n_chk = 0, n_bad = 0;

  sd_cmd_path #(.CTO(64), .DTW(DTW)) uut (.*);

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'd0};
    for (int i = 46; i >= 7; i--) if (r[i]) r[i-:8] = r[i-:8] ^ 8'h89;
    return r[6:0];
  endfunction

  function automatic logic [47:0] short_rsp(input logic [5:0] idx, input logic [31:0] d);
    logic [39:0] h;
    h = {2'b00, idx, d};
    return {h, ref_crc(h), 1'b1};
  endfunction

  task automatic clear_all();
    @(negedge clk); clr_wr = 1'b1; clr_data = 32'h1FE0_0FFF;
    @(negedge clk); clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic send_cmd(input logic [5:0] idx, input logic [1:0] wc, input logic [31:0] arg,
                          input int inject_at, output logic [47:0] fr, output int n);
    @(negedge clk);
    cmd_wdata = {1'b1, 2'b00, wc, 2'b00, idx}; arg_in = arg; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    n = 0; fr = '0;
    while (cmd_oe && n < 200) begin
      if (n == 0) chk("R2 active while sending", status[13], 1);
      if (n == inject_at) begin
        cmd_wdata = {1'b1, 2'b00, 2'b00, 2'b00, 6'd0}; arg_in = 32'hFFFF_FFFF; cmd_wr = 1'b1;
      end
      fr = {fr[46:0], cmd_out};
      n++;
      @(negedge clk); cmd_wr = 1'b0;
    end
  endtask

  task automatic drive_resp(input logic [135:0] f, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      cmd_in = f[i];
      @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 status", status, 0);
    chk("R11 oe", cmd_oe, 0);
    chk("R11 line idle high", cmd_out, 1);
  endtask

  task automatic t_no_resp();
    logic [47:0] fr; int n;
    send_cmd(6'd0, 2'b00, 32'h0, -1, fr, n);
    chk("R1 length", n, 48);
    chk("R1 frame cmd0", fr, 48'h4000_0000_0095);
    chk("R2 sent flag only", status, 32'h80);
    clear_all();
    send_cmd(6'd8, 2'b00, 32'h1AA, -1, fr, n);
    chk("R1 frame cmd8", fr, {2'b01, 6'd8, 32'h1AA, ref_crc({2'b01, 6'd8, 32'h1AA}), 1'b1});
    clear_all();
  endtask

  task automatic t_long();
    logic [47:0] fr; int n;
    logic [127:0] L;
    L = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAA7;
    send_cmd(6'd2, 2'b11, 32'h0, -1, fr, n);
    drive_resp({2'b00, 6'h3F, L[127:1], 1'b1}, 136);
    chk("R5 done flag", status, 32'h40);
    chk("R5 resp0", resp0, L[127:96]);
    chk("R5 resp1", resp1, L[95:64]);
    chk("R5 resp2", resp2, L[63:32]);
    chk("R5 resp3", resp3, {L[31:1], 1'b0});
    clear_all();
  endtask

  task automatic t_short();
    logic [47:0] fr; int n;
    send_cmd(6'd17, 2'b01, 32'h0000_1234, -1, fr, n);
    chk("R1 frame cmd17", fr, {2'b01, 6'd17, 32'h1234, ref_crc({2'b01, 6'd17, 32'h1234}), 1'b1});
    drive_resp({88'h0, short_rsp(6'd17, 32'h0000_0900)}, 48);
    chk("R3 done flag", status, 32'h40);
    chk("R3 resp0", resp0, 32'h0000_0900);
    chk("R3 resp1 kept", resp1, 32'h0123_4567);
    chk("R3 resp3 kept", resp3, 32'h5555_AAA6);
    clear_all();
  endtask

  task automatic t_crc();
    logic [47:0] fr; int n;
    logic [47:0] bad;
    bad = short_rsp(6'd13, 32'hCAFE_0001) ^ 48'h2;
    send_cmd(6'd13, 2'b01, 32'h0, -1, fr, n);
    drive_resp({88'h0, bad}, 48);
    chk("R4 crc fail only", status, 32'h1);
    clear_all();
    send_cmd(6'd13, 2'b10, 32'h0, -1, fr, n);
    drive_resp({88'h0, bad}, 48);
    chk("R4 unchecked code done", status, 32'h40);
    chk("R4 unchecked resp0", resp0, 32'hCAFE_0001);
    clear_all();
  endtask

  task automatic t_timeout();
    logic [47:0] fr; int n;
    send_cmd(6'd5, 2'b01, 32'h0, -1, fr, n);
    repeat (63) @(posedge clk);
    @(negedge clk);
    chk("R6 not yet timed out", status, 32'h2000);
    @(posedge clk); @(negedge clk);
    chk("R6 timeout flag", status, 32'h4);
    clear_all();
  endtask

  task automatic t_busy_end();
    logic [47:0] fr; int n;
    dtimer_in = 16'd1000;
    send_cmd(6'd7, 2'b01, 32'h0, -1, fr, n);
    dat0_in = 1'b0;
    drive_resp({88'h0, short_rsp(6'd7, 32'h0000_0700)}, 48);
    chk("R7 busy shown", status, 32'h0010_2040);
    repeat (5) @(negedge clk);
    chk("R7 still busy", status[20], 1);
    dat0_in = 1'b1;
    @(negedge clk);
    chk("R7 busy end", status, 32'h0020_0040);
    @(negedge clk); clr_wr = 1'b1; clr_data = 32'h40;
    @(negedge clk); clr_wr = 1'b0; clr_data = '0;
    chk("R9 partial clear", status, 32'h0020_0000);
    clear_all();
    chk("R9 full clear", status, 0);
  endtask

  task automatic t_busy_timeout();
    logic [47:0] fr; int n;
    dtimer_in = 16'd10;
    send_cmd(6'd7, 2'b01, 32'h0, -1, fr, n);
    dat0_in = 1'b0;
    drive_resp({88'h0, short_rsp(6'd7, 32'h0000_0800)}, 48);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R8 before expiry", status, 32'h0010_2040);
    @(posedge clk); @(negedge clk);
    chk("R8 data timeout", status, 32'h48);
    dat0_in = 1'b1;
    clear_all();
  endtask

  task automatic t_abort();
    logic [47:0] fr; int n;
    send_cmd(6'd17, 2'b00, 32'hABCD_0000, 5, fr, n);
    chk("R10 busy write ignored frame", fr,
        {2'b01, 6'd17, 32'hABCD_0000, ref_crc({2'b01, 6'd17, 32'hABCD_0000}), 1'b1});
    chk("R10 busy write ignored length", n, 48);
    clear_all();
    @(negedge clk);
    cmd_wdata = {1'b1, 2'b00, 2'b01, 2'b00, 6'd17}; arg_in = 0; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    repeat (3) @(negedge clk);
    cmd_wdata = 13'h0; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    chk("R10 abort idles line", cmd_oe, 0);
    chk("R10 abort inactive", status, 0);
    repeat (80) @(negedge clk);
    chk("R10 abort sets no flag", status, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; clr_wr = 1'b0; cmd_in = 1'b1; dat0_in = 1'b1;
    cmd_wdata = '0; arg_in = '0; clr_data = '0; dtimer_in = 16'd100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_resp();
    t_long();
    t_short();
    t_crc();
    t_timeout();
    t_busy_end();
    t_busy_timeout();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule